// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a flash device and decides whether a program or erase operation inside the device has finished. A start pulse begins the check. The block then fetches status bytes through a simple request/acknowledge read port. It compares the toggle bit of each status byte with the one before it in the same pair. It also looks at the exceeded-limit bit. Each run ends with a single-cycle done pulse. The pulse carries either a success flag or a failure indication, and a separate flag marks a timeout.

The exceeded-limit bit can rise in the same moment that the toggle bit stops moving. For that reason, a set limit bit does not by itself mean failure. The block fetches one more pair and decides from that pair. A failure of either kind sends the device a reset command write, which returns the device to array reads, and only then reports done.

An abort input drops polling at any point. The block takes no further action and reports nothing. The next start always begins with a fresh pair of reads.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `wr_req_o`, `done_o`, `ok_o` and `tmo_o` are all 0.
- R2: A start pulse while idle raises `rd_req_o` on the next cycle. `rd_req_o` stays high until `rd_ack_i` returns, and each acknowledge consumes one status byte from `rd_data_i`. A start pulse while busy has no effect.
- R3: Reads are taken in pairs. If the toggle bit (bit 6 by default) is equal in both reads of a pair, `done_o` and `ok_o` go high in the cycle after the second acknowledge, and no write is issued.
- R4: If the toggle bit differs within a pair and the exceeded-limit bit (bit 5) of the second read of that pair is 0, a new pair of reads follows. The new pair is compared only within itself.
- R5: If the toggle bit differs within a pair and bit 5 of the second read is 1, exactly one extra pair is read. An equal toggle bit in that extra pair gives success.
- R6: If the toggle bit also differs in the extra pair, `wr_req_o` rises with address `RST_ADDR` and data `RST_DATA` (default 8'hF0) and is held until `wr_ack_i`. `done_o` then goes high with `ok_o`=0 in the cycle after the write acknowledge.
- R7: `done_o` is high for exactly one cycle per run. `ok_o` and `tmo_o` are 0 whenever `done_o` is 0.
- R8: `abort_i` while busy returns the block to idle on the next cycle, with no done pulse. The following start performs two new reads and does not reuse any earlier sample.
- R9: When `MAX_PAIRS` is nonzero (default 4), the `MAX_PAIRS`-th pair that toggles with bit 5 clear ends the run as a failure. The failure issues the reset write and then reports `done_o` with `tmo_o`=1 and `ok_o`=0.
- R10: With the default toggle selection (bit 6), a change in bit 2 alone is not treated as toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a polling run |
| abort_i | input | 1 | Abandon the current run |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Status read acknowledge, data valid |
| rd_data_i | input | DW | Status byte |
| wr_req_o | output | 1 | Reset command write request |
| wr_addr_o | output | AW | Reset command address |
| wr_data_o | output | DW | Reset command data |
| wr_ack_i | input | 1 | Write acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Success flag, valid with done |
| tmo_o | output | 1 | Timeout flag, valid with done |

## Verification
The read request is due one cycle after a start. A success result is due one cycle after the acknowledge of the deciding read. The reset write request is due one cycle after a failing read, and the failure result is due one cycle after the write acknowledge. The bench drives every acknowledge at a falling edge and samples at the falling edge that follows the sampling rising edge, so each expectation is checked exactly in its due cycle. A scoreboard queue pairs every done pulse with the result predicted when the run began.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int DW        = 8,
  parameter int AW        = 16,
  parameter int TOG_BIT   = 6,
  parameter int ERR_BIT   = 5,
  parameter logic [AW-1:0] RST_ADDR = '0,
  parameter logic [DW-1:0] RST_DATA = 8'hF0,
  parameter int MAX_PAIRS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_ack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ok_o,
  output logic          tmo_o
);
  localparam int TB = (TOG_BIT == 2) ? 2 : 6;
  localparam int CW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS + 1) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RA, S_RB, S_RC, S_RD, S_WR} st_t;
  st_t st;

  logic          tog_q, tmo_q;
  logic [CW-1:0] cnt_q;
  logic          cur_tog, cur_err, lim_hit;

  assign cur_tog   = rd_data_i[TB];
  assign cur_err   = rd_data_i[ERR_BIT];
  assign rd_req_o  = (st == S_RA) || (st == S_RB) || (st == S_RC) || (st == S_RD);
  assign wr_req_o  = (st == S_WR);
  assign busy_o    = (st != S_IDLE);
  assign wr_addr_o = RST_ADDR;
  assign wr_data_o = RST_DATA;

  generate
    if (MAX_PAIRS == 0) begin : g_nolim
      assign lim_hit = 1'b0;
    end else begin : g_lim
      assign lim_hit = (cnt_q == CW'(MAX_PAIRS - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tog_q  <= 1'b0;
      tmo_q  <= 1'b0;
      cnt_q  <= '0;
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      tmo_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      tmo_o  <= 1'b0;
      if (abort_i && st != S_IDLE) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start_i) begin
            st    <= S_RA;
            cnt_q <= '0;
            tmo_q <= 1'b0;
          end
          S_RA: if (rd_ack_i) begin
            tog_q <= cur_tog;
            st    <= S_RB;
          end
          S_RB: if (rd_ack_i) begin
            if (cur_tog == tog_q) begin
              done_o <= 1'b1;
              ok_o   <= 1'b1;
              st     <= S_IDLE;
            end else if (cur_err) begin
              st <= S_RC;
            end else if (lim_hit) begin
              tmo_q <= 1'b1;
              st    <= S_WR;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              st    <= S_RA;
            end
          end
          S_RC: if (rd_ack_i) begin
            tog_q <= cur_tog;
            st    <= S_RD;
          end
          S_RD: if (rd_ack_i) begin
            if (cur_tog == tog_q) begin
              done_o <= 1'b1;
              ok_o   <= 1'b1;
              st     <= S_IDLE;
            end else begin
              st <= S_WR;
            end
          end
          S_WR: if (wr_ack_i) begin
            done_o <= 1'b1;
            tmo_o  <= tmo_q;
            st     <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module toggle_poll_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic abort_i,
  input logic rd_req_o,
  input logic rd_ack_i,
  input logic wr_req_o,
  input logic wr_ack_i,
  input logic busy_o,
  input logic done_o,
  input logic ok_o,
  input logic tmo_o
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_flags_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (!ok_o && !tmo_o));
  p_tmo_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && tmo_o) |-> !ok_o);
  p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o));
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i && !abort_i) |=> rd_req_o);
  p_start_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> rd_req_o);
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && busy_o) |=> (!busy_o && !done_o));
  p_wr_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && wr_ack_i && !abort_i) |=> (done_o && !ok_o));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rd_req_o && !wr_req_o));
endmodule

bind toggle_poll_ctrl toggle_poll_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
  .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .wr_req_o(wr_req_o),
  .wr_ack_i(wr_ack_i), .busy_o(busy_o), .done_o(done_o),
  .ok_o(ok_o), .tmo_o(tmo_o)
);

// File: tb/test_toggle_poll_ctrl.sv
module test_toggle_poll_ctrl;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, start_i = 0, abort_i = 0;
  logic rd_ack_i = 0, wr_ack_i = 0;
  logic [7:0]  rd_data_i = '0;
  logic rd_req_o, wr_req_o, busy_o, done_o, ok_o, tmo_o;
  logic [15:0] wr_addr_o;
  logic [7:0]  wr_data_o;

  int tests = 0, fails = 0;
  logic [1:0] expq[$];
  logic prev_done = 0;
  logic finished = 0;

  always #(CLK_P/2) clk = ~clk;

  toggle_poll_ctrl i_toggle_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_ack_i(wr_ack_i), .busy_o(busy_o), .done_o(done_o),
    .ok_o(ok_o), .tmo_o(tmo_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected {ok,tmo} on every done pulse (R7)
  always @(negedge clk) if (rst_n) begin
    if (done_o) begin
      check("R7 done width", prev_done, 0);
      if (expq.size() == 0) check("R7 unexpected done", 1, 0);
      else check("R3/R5/R6/R9 result {ok,tmo}", {ok_o, tmo_o}, expq.pop_front());
    end else if (ok_o || tmo_o) begin
      check("R7 flags outside done", {ok_o, tmo_o}, 0);
    end
    prev_done = done_o;
  end

  task automatic kick(input logic [1:0] exp);
    expq.push_back(exp);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic rd(input logic [7:0] b);
    int n = 0;
    while (!rd_req_o && n < 50) begin @(negedge clk); n++; end
    check("R2 read requested", rd_req_o, 1);
    rd_ack_i = 1; rd_data_i = b;
    @(negedge clk);
    rd_ack_i = 0; rd_data_i = '0;
  endtask

  task automatic wr();
    int n = 0;
    while (!wr_req_o && n < 50) begin @(negedge clk); n++; end
    check("R6 write requested", wr_req_o, 1);
    check("R6 write addr", wr_addr_o, 16'h0000);
    check("R6 write data", wr_data_o, 8'hF0);
    wr_ack_i = 1;
    @(negedge clk);
    wr_ack_i = 0;
  endtask

  task automatic settle(input string req);
    check({req, " no read after decision"}, rd_req_o, 0);
    repeat (3) @(negedge clk);
    check({req, " idle"}, busy_o, 0);
    check({req, " result consumed"}, expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy_o, 0);
    check("R1 rd_req", rd_req_o, 0);
    check("R1 wr_req", wr_req_o, 0);
    check("R1 done/ok/tmo", {done_o, ok_o, tmo_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3: stable toggle -> ok
    kick(2'b10);
    check("R2 rd_req next cycle", rd_req_o, 1);
    rd(8'h00); rd(8'h00);
    settle("R3");

    // R10: bit 2 alone changes
    kick(2'b10);
    rd(8'h04); rd(8'h00);
    settle("R10");

    // R4: toggling pair then stable pair; start while busy ignored (R2)
    kick(2'b10);
    rd(8'h40);
    start_i = 1; @(negedge clk); start_i = 0;
    rd(8'h00); rd(8'h40); rd(8'h40);
    settle("R4");

    // R4: error bit on first read only is not used
    kick(2'b10);
    rd(8'h60); rd(8'h00); rd(8'h00); rd(8'h00);
    settle("R4 err from second read");

    // R5: toggling with err -> extra pair stable -> ok
    kick(2'b10);
    rd(8'h40); rd(8'h20); rd(8'h00); rd(8'h00);
    settle("R5");

    // R6: extra pair still toggles -> reset write, fail
    kick(2'b00);
    rd(8'h40); rd(8'h20); rd(8'h60); rd(8'h20);
    check("R6 no done before write", done_o, 0);
    wr();
    settle("R6");

    // R9: four toggling pairs -> timeout
    kick(2'b01);
    for (int i = 0; i < 4; i++) begin rd(8'h40); rd(8'h00); end
    wr();
    settle("R9");

    // R8: abort, then fresh pair
    expq.push_back(2'b10);
    start_i = 1; @(negedge clk); start_i = 0;
    rd(8'h40);
    abort_i = 1; @(negedge clk); abort_i = 0;
    check("R8 idle after abort", busy_o, 0);
    check("R8 no read after abort", rd_req_o, 0);
    repeat (2) @(negedge clk);
    check("R8 no done after abort", expq.size(), 1);
    start_i = 1; @(negedge clk); start_i = 0;
    rd(8'h00); rd(8'h00);
    settle("R8");

    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 5000) begin @(negedge clk); cyc++; end
    if (!finished) check("watchdog", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule